// File: doc/BRIEF.md
# Key-protected configuration register file

This block holds a small map of 32-bit system configuration words behind a plain word-addressed register bus. The host accesses it through a write strobe, a read strobe, a word address and write data. Every access completes in one cycle, so the bus has no back-pressure. Read data and the error flag are registered and appear in the cycle after the access.

A write-protect latch guards the map, and it comes out of reset engaged. A 16-bit magic value written to the close word engages it. A second magic value written to the open word releases it. While the latch is engaged, every other write is dropped and flagged.

Each word address carries one of four access classes: read-write, read-only, write-only or unmapped. An access that its class forbids raises the error output for one cycle. One read-write word acts as a reset control. Setting its bit 0 by an accepted write emits a one-cycle soft-reset request. A bank of pin-configuration words is sized by a parameter.

Top module: `kcr_keyed_regs`

## Requirements
- R1: After reset, the following values are read back:
  - word 3 (protect status, bit 0) is 1;
  - each PLL control word (words 64, 65, 66) is 0x0001A008;
  - the UART clock word (word 85) is 0x00003F03;
  - the PLL status word (word 67) is 0x0000003F;
  - the boot-mode word (word 151) is 0x00000001.
- R2: A write to word 1 whose data bits [15:0] equal 0x767B engages protection, so that word 3 reads 1. Any other value at word 1 leaves protection unchanged. Writes to word 1 never raise the error, whether protection is engaged or not.
- R3: A write to word 2 whose data bits [15:0] equal 0xDF0D releases protection, so that word 3 reads 0. The upper data bits are ignored. Any other value at word 2 is ignored without error.
- R4: While protection is engaged, writes to read-write words and to the trigger words (387, 389) are discarded and raise the error. This holds even when the write data would request a soft reset.
- R5: The write-only words are 1, 2, 387 and 389. A read of any of them returns 0 and raises the error. An unprotected write to word 387 raises no error.
- R6: The read-only words are 3, 67, 151 and 332 (the ID code). A write to any of them raises the error and leaves the read-back value unchanged.
- R7: A write to word 0 stores only data bit 0. Word 0 then reads that bit in position 0, with all other bits 0.
- R8: An unprotected write to word 128 with data bit 0 set produces soft_rst_req high for exactly one cycle, in the cycle after the write. Word 128 keeps the written value, and no other stored word changes. A write with bit 0 clear produces no request.
- R9: An unmapped word returns 0 on read and raises the error. A write to an unmapped word is discarded and raises the error.
- R10: rd_data and acc_err are valid in the cycle after the access, and acc_err lasts one cycle per access. rd_data is 0 in any cycle that did not follow an allowed read. When wr_en and rd_en are high together, only the write is performed, and rd_data is 0.
- R11: The pin-configuration words start at word 448, one word per pin. Each resets to 0x00001601 and is read-write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, ignored when wr_en is high |
| addr | input | ADDR_W | Word address (byte offset divided by 4) |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, registered, zero when no allowed read |
| acc_err | output | 1 | One-cycle flag for an illegal or discarded access |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
A wrong protect latch shows up at the ports one cycle later: a locked write is not flagged, or a later read of the targeted word returns the new data instead of the old value. A wrong access-class decode shows up the cycle after the access, as a missing or spurious error or as nonzero data from a write-only or unmapped word. A wrong write mask or reset value is exposed by the next read of that word. A misrouted soft-reset request appears as a pulse that is missing, lasts too long, or occurs while locked.

// File: rtl/kcr_pkg.sv
package kcr_pkg;
  typedef enum logic [1:0] {ACC_NONE, ACC_RO, ACC_WO, ACC_RW} acc_e;
  typedef enum logic [3:0] {
    SEL_NONE, SEL_STORE, SEL_LOCK, SEL_UNLOCK, SEL_LOCKSTA,
    SEL_PLLSTA, SEL_BOOT, SEL_ID, SEL_TRIG
  } sel_e;

  // word addresses (byte offset / 4)
  localparam int unsigned W_SCL    = 0;
  localparam int unsigned W_CLOSE  = 1;
  localparam int unsigned W_OPEN   = 2;
  localparam int unsigned W_LSTA   = 3;
  localparam int unsigned W_PLL    = 64;
  localparam int unsigned W_PLLSTA = 67;
  localparam int unsigned W_UART   = 85;
  localparam int unsigned W_RSTC   = 128;
  localparam int unsigned W_BOOT   = 151;
  localparam int unsigned W_ID     = 332;
  localparam int unsigned W_CAL    = 387;
  localparam int unsigned W_REF    = 389;
  localparam int unsigned W_PIN    = 448;

  localparam logic [15:0] KEY_CLOSE = 16'h767B;
  localparam logic [15:0] KEY_OPEN  = 16'hDF0D;
endpackage

// File: rtl/kcr_decode.sv
module kcr_decode
  import kcr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_PLL = 3,
  parameter int unsigned NUM_PIN = 8,
  parameter int unsigned SLOT_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_e              acc,
  output sel_e              sel,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [ADDR_W-1:0] A_SCL    = ADDR_W'(W_SCL);
  localparam logic [ADDR_W-1:0] A_CLOSE  = ADDR_W'(W_CLOSE);
  localparam logic [ADDR_W-1:0] A_OPEN   = ADDR_W'(W_OPEN);
  localparam logic [ADDR_W-1:0] A_LSTA   = ADDR_W'(W_LSTA);
  localparam logic [ADDR_W-1:0] A_PLL    = ADDR_W'(W_PLL);
  localparam logic [ADDR_W-1:0] A_PLLEND = ADDR_W'(W_PLL + NUM_PLL);
  localparam logic [ADDR_W-1:0] A_PLLSTA = ADDR_W'(W_PLLSTA);
  localparam logic [ADDR_W-1:0] A_UART   = ADDR_W'(W_UART);
  localparam logic [ADDR_W-1:0] A_RSTC   = ADDR_W'(W_RSTC);
  localparam logic [ADDR_W-1:0] A_BOOT   = ADDR_W'(W_BOOT);
  localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(W_ID);
  localparam logic [ADDR_W-1:0] A_CAL    = ADDR_W'(W_CAL);
  localparam logic [ADDR_W-1:0] A_REF    = ADDR_W'(W_REF);
  localparam logic [ADDR_W-1:0] A_PIN    = ADDR_W'(W_PIN);
  localparam logic [ADDR_W-1:0] A_PINEND = ADDR_W'(W_PIN + NUM_PIN);

  always_comb begin
    acc  = ACC_NONE;
    sel  = SEL_NONE;
    slot = '0;
    if (addr == A_SCL) begin
      acc = ACC_RW; sel = SEL_STORE; slot = '0;
    end else if (addr == A_CLOSE) begin
      acc = ACC_WO; sel = SEL_LOCK;
    end else if (addr == A_OPEN) begin
      acc = ACC_WO; sel = SEL_UNLOCK;
    end else if (addr == A_LSTA) begin
      acc = ACC_RO; sel = SEL_LOCKSTA;
    end else if (addr == A_PLLSTA) begin
      acc = ACC_RO; sel = SEL_PLLSTA;
    end else if (addr >= A_PLL && addr < A_PLLEND) begin
      acc = ACC_RW; sel = SEL_STORE;
      slot = SLOT_W'(addr - A_PLL) + SLOT_W'(1);
    end else if (addr == A_UART) begin
      acc = ACC_RW; sel = SEL_STORE; slot = SLOT_W'(NUM_PLL + 1);
    end else if (addr == A_RSTC) begin
      acc = ACC_RW; sel = SEL_STORE; slot = SLOT_W'(NUM_PLL + 2);
    end else if (addr == A_BOOT) begin
      acc = ACC_RO; sel = SEL_BOOT;
    end else if (addr == A_ID) begin
      acc = ACC_RO; sel = SEL_ID;
    end else if (addr == A_CAL || addr == A_REF) begin
      acc = ACC_WO; sel = SEL_TRIG;
    end else if (addr >= A_PIN && addr < A_PINEND) begin
      acc = ACC_RW; sel = SEL_STORE;
      slot = SLOT_W'(addr - A_PIN) + SLOT_W'(NUM_PLL + 3);
    end
  end
endmodule

// File: rtl/kcr_lock.sv
module kcr_lock
  import kcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        close_wr,
  input  logic        open_wr,
  input  logic [15:0] key,
  output logic        locked
);
  logic locked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
    end else if (close_wr && key == KEY_CLOSE) begin
      locked_q <= 1'b1;
    end else if (open_wr && key == KEY_OPEN) begin
      locked_q <= 1'b0;
    end
  end

  assign locked = locked_q;

  AST_CLOSE_KEY_ENGAGES: assert property (@(posedge clk) disable iff (!rst_n)
    (close_wr && key == KEY_CLOSE) |=> locked); // R2
  AST_OPEN_KEY_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (open_wr && !close_wr && key == KEY_OPEN) |=> !locked); // R3
  AST_LOCK_HOLDS_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(close_wr || open_wr) |=> $stable(locked)); // R2
endmodule

// File: rtl/kcr_store.sv
module kcr_store #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_PLL  = 3,
  parameter int unsigned NUM_SLOT = 14,
  parameter int unsigned SLOT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SLOT_W-1:0] rslot,
  output logic [DATA_W-1:0] rdata
);
  function automatic logic [DATA_W-1:0] init_of(int unsigned s);
    if (s >= 1 && s <= NUM_PLL) return DATA_W'(32'h0001_A008);
    else if (s == NUM_PLL + 1)  return DATA_W'(32'h0000_3F03);
    else if (s >= NUM_PLL + 3)  return DATA_W'(32'h0000_1601);
    else                        return '0;
  endfunction

  function automatic logic [DATA_W-1:0] mask_of(int unsigned s);
    if (s == 0) return DATA_W'(1);
    else        return '1;
  endfunction

  logic [DATA_W-1:0] word [NUM_SLOT];

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    localparam logic [DATA_W-1:0] INIT = init_of(g);
    localparam logic [DATA_W-1:0] MASK = mask_of(g);
    logic [DATA_W-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r <= INIT;
      end else if (we && wslot == SLOT_W'(g)) begin
        r <= wdata & MASK;
      end
    end
    assign word[g] = r;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_SLOT; i++) begin
      if (rslot == SLOT_W'(i)) rdata = word[i];
    end
  end
endmodule

// File: rtl/kcr_keyed_regs.sv
module kcr_keyed_regs
  import kcr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_PLL    = 3,
  parameter int unsigned NUM_PIN    = 8,
  parameter logic [31:0] PLLSTA_VAL = 32'h0000_003F,
  parameter logic [31:0] BOOT_VAL   = 32'h0000_0001,
  parameter logic [31:0] ID_VAL     = 32'h1A5C_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              acc_err,
  output logic              soft_rst_req
);
  localparam int unsigned NUM_SLOT = NUM_PLL + NUM_PIN + 3;
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOT);
  localparam logic [SLOT_W-1:0] SLOT_RST = SLOT_W'(NUM_PLL + 2);

  acc_e              acc;
  sel_e              sel;
  logic [SLOT_W-1:0] slot;
  logic              locked;
  logic [DATA_W-1:0] store_rd;

  kcr_decode #(.ADDR_W(ADDR_W), .NUM_PLL(NUM_PLL), .NUM_PIN(NUM_PIN), .SLOT_W(SLOT_W))
    u_dec (.addr(addr), .acc(acc), .sel(sel), .slot(slot));

  logic wr_hit, key_wr, store_we, rd_ok, err_d, srst_d;
  logic [DATA_W-1:0] rd_mux, rd_d;

  assign wr_hit   = wr_en && (acc == ACC_RW || acc == ACC_WO);
  assign key_wr   = (sel == SEL_LOCK) || (sel == SEL_UNLOCK);
  assign store_we = wr_hit && !locked && sel == SEL_STORE;
  assign rd_ok    = rd_en && !wr_en && (acc == ACC_RO || acc == ACC_RW);
  assign err_d    = (wr_en && !wr_hit)
                 || (wr_hit && !key_wr && locked)
                 || (rd_en && !wr_en && !(acc == ACC_RO || acc == ACC_RW));
  assign srst_d   = store_we && slot == SLOT_RST && wr_data[0];

  kcr_lock u_lock (
    .clk(clk), .rst_n(rst_n),
    .close_wr(wr_en && sel == SEL_LOCK),
    .open_wr(wr_en && sel == SEL_UNLOCK),
    .key(wr_data[15:0]), .locked(locked)
  );

  kcr_store #(.DATA_W(DATA_W), .NUM_PLL(NUM_PLL), .NUM_SLOT(NUM_SLOT), .SLOT_W(SLOT_W))
    u_store (.clk(clk), .rst_n(rst_n), .we(store_we), .wslot(slot),
             .wdata(wr_data), .rslot(slot), .rdata(store_rd));

  always_comb begin
    unique case (sel)
      SEL_STORE:   rd_mux = store_rd;
      SEL_LOCKSTA: rd_mux = DATA_W'(locked);
      SEL_PLLSTA:  rd_mux = DATA_W'(PLLSTA_VAL);
      SEL_BOOT:    rd_mux = DATA_W'(BOOT_VAL);
      SEL_ID:      rd_mux = DATA_W'(ID_VAL);
      default:     rd_mux = '0;
    endcase
  end

  assign rd_d = rd_ok ? rd_mux : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data      <= '0;
      acc_err      <= 1'b0;
      soft_rst_req <= 1'b0;
    end else begin
      rd_data      <= rd_d;
      acc_err      <= err_d;
      soft_rst_req <= srst_d;
    end
  end

  AST_LOCKED_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && sel == SEL_STORE) |=> acc_err); // R4
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && acc == ACC_WO) |=> (acc_err && rd_data == '0)); // R5
  AST_RO_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc == ACC_RO) |=> acc_err); // R6
  AST_SRST_ONLY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |-> !$past(locked)); // R8
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && acc == ACC_NONE) |=> (acc_err && rd_data == '0)); // R9
  AST_DUAL_STROBE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> rd_data == '0); // R10
endmodule

// File: tb/tb_kcr_keyed_regs.sv
module tb_kcr_keyed_regs;
  localparam logic [31:0] ID = 32'h1A5C_0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic acc_err, soft_rst_req;

  always #4 clk = ~clk;

  kcr_keyed_regs #(.ID_VAL(ID)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .acc_err(acc_err), .soft_rst_req(soft_rst_req)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [9:0]  a;
    logic [31:0] d;
    logic [31:0] erd;
    logic        eerr;
    logic        esrst;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,10'd3,  32'h0,        32'h1,        1'b0,1'b0,8'd1},  // R1
    '{1'b0,1'b1,10'd64, 32'h0,        32'h0001A008, 1'b0,1'b0,8'd1},  // R1
    '{1'b0,1'b1,10'd66, 32'h0,        32'h0001A008, 1'b0,1'b0,8'd1},  // R1
    '{1'b0,1'b1,10'd85, 32'h0,        32'h00003F03, 1'b0,1'b0,8'd1},  // R1
    '{1'b0,1'b1,10'd67, 32'h0,        32'h0000003F, 1'b0,1'b0,8'd1},  // R1
    '{1'b0,1'b1,10'd151,32'h0,        32'h1,        1'b0,1'b0,8'd1},  // R1
    '{1'b0,1'b1,10'd448,32'h0,        32'h00001601, 1'b0,1'b0,8'd11}, // R11
    '{1'b1,1'b0,10'd64, 32'h1234,     32'h0,        1'b1,1'b0,8'd4},  // R4
    '{1'b0,1'b0,10'd64, 32'h0,        32'h0,        1'b0,1'b0,8'd10}, // R10
    '{1'b0,1'b1,10'd64, 32'h0,        32'h0001A008, 1'b0,1'b0,8'd4},  // R4
    '{1'b1,1'b0,10'd0,  32'hFFFFFFFF, 32'h0,        1'b1,1'b0,8'd4},  // R4
    '{1'b1,1'b0,10'd2,  32'hDF0C,     32'h0,        1'b0,1'b0,8'd3},  // R3
    '{1'b0,1'b1,10'd3,  32'h0,        32'h1,        1'b0,1'b0,8'd3},  // R3
    '{1'b1,1'b0,10'd2,  32'hFFFFDF0D, 32'h0,        1'b0,1'b0,8'd3},  // R3
    '{1'b0,1'b1,10'd3,  32'h0,        32'h0,        1'b0,1'b0,8'd3},  // R3
    '{1'b1,1'b0,10'd64, 32'h1234,     32'h0,        1'b0,1'b0,8'd10}, // R10
    '{1'b0,1'b1,10'd64, 32'h0,        32'h1234,     1'b0,1'b0,8'd10}, // R10
    '{1'b1,1'b0,10'd0,  32'hFFFFFFFF, 32'h0,        1'b0,1'b0,8'd7},  // R7
    '{1'b0,1'b1,10'd0,  32'h0,        32'h1,        1'b0,1'b0,8'd7},  // R7
    '{1'b1,1'b0,10'd67, 32'h0,        32'h0,        1'b1,1'b0,8'd6},  // R6
    '{1'b0,1'b1,10'd67, 32'h0,        32'h0000003F, 1'b0,1'b0,8'd6},  // R6
    '{1'b1,1'b0,10'd332,32'h0,        32'h0,        1'b1,1'b0,8'd6},  // R6
    '{1'b0,1'b1,10'd332,32'h0,        ID,           1'b0,1'b0,8'd6},  // R6
    '{1'b0,1'b1,10'd387,32'h0,        32'h0,        1'b1,1'b0,8'd5},  // R5
    '{1'b0,1'b1,10'd1,  32'h0,        32'h0,        1'b1,1'b0,8'd5},  // R5
    '{1'b0,1'b1,10'd389,32'h0,        32'h0,        1'b1,1'b0,8'd5},  // R5
    '{1'b1,1'b0,10'd387,32'h1,        32'h0,        1'b0,1'b0,8'd5},  // R5
    '{1'b1,1'b0,10'd128,32'h3,        32'h0,        1'b0,1'b1,8'd8},  // R8
    '{1'b0,1'b1,10'd128,32'h0,        32'h3,        1'b0,1'b0,8'd8},  // R8
    '{1'b1,1'b0,10'd128,32'h2,        32'h0,        1'b0,1'b0,8'd8},  // R8
    '{1'b0,1'b1,10'd5,  32'h0,        32'h0,        1'b1,1'b0,8'd9},  // R9
    '{1'b1,1'b0,10'd5,  32'hAAAA,     32'h0,        1'b1,1'b0,8'd9},  // R9
    '{1'b0,1'b1,10'd5,  32'h0,        32'h0,        1'b1,1'b0,8'd9},  // R9
    '{1'b1,1'b0,10'd455,32'hAB,       32'h0,        1'b0,1'b0,8'd11}, // R11
    '{1'b0,1'b1,10'd455,32'h0,        32'hAB,       1'b0,1'b0,8'd11}, // R11
    '{1'b0,1'b1,10'd449,32'h0,        32'h00001601, 1'b0,1'b0,8'd11}, // R11
    '{1'b1,1'b1,10'd65, 32'h5,        32'h0,        1'b0,1'b0,8'd10}, // R10
    '{1'b0,1'b1,10'd65, 32'h0,        32'h5,        1'b0,1'b0,8'd10}, // R10
    '{1'b1,1'b0,10'd1,  32'h767A,     32'h0,        1'b0,1'b0,8'd2},  // R2
    '{1'b0,1'b1,10'd3,  32'h0,        32'h0,        1'b0,1'b0,8'd2},  // R2
    '{1'b1,1'b0,10'd1,  32'hFFFF767B, 32'h0,        1'b0,1'b0,8'd2},  // R2
    '{1'b0,1'b1,10'd3,  32'h0,        32'h1,        1'b0,1'b0,8'd2},  // R2
    '{1'b1,1'b0,10'd128,32'h1,        32'h0,        1'b1,1'b0,8'd4},  // R4
    '{1'b0,1'b1,10'd128,32'h0,        32'h2,        1'b0,1'b0,8'd4},  // R4
    '{1'b1,1'b0,10'd1,  32'h767B,     32'h0,        1'b0,1'b0,8'd2},  // R2
    '{1'b0,1'b1,10'd3,  32'h0,        32'h1,        1'b0,1'b0,8'd2}   // R2
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [31:0] rd_e,
                       input logic err_e, input logic srst_e);
    n_chk++;
    if (rd_data !== rd_e || acc_err !== err_e || soft_rst_req !== srst_e) begin
      n_bad++;
      $display("FAIL %s: rd=%h err=%b srst=%b expected rd=%h err=%b srst=%b",
               tag, rd_data, acc_err, soft_rst_req, rd_e, err_e, srst_e);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic access(input logic w, input logic r, input logic [9:0] a,
                        input logic [31:0] d);
    wr_en = w; rd_en = r; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", 32'h0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].rd, VEC[i].a, VEC[i].d);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].erd, VEC[i].eerr, VEC[i].esrst);
    end

    // R8: request lasts exactly one cycle
    access(1'b1, 1'b0, 10'd2, 32'hDF0D);
    access(1'b1, 1'b0, 10'd128, 32'h1);
    check("R8 pulse high", 32'h0, 1'b0, 1'b1);
    access(1'b0, 1'b0, 10'd0, 32'h0);
    check("R8 pulse gone", 32'h0, 1'b0, 1'b0);
    access(1'b0, 1'b1, 10'd455, 32'h0);
    check("R8 contents kept", 32'hAB, 1'b0, 1'b0);

    // R1: mid-run reset restores defaults and engages protection
    access(1'b1, 1'b0, 10'd64, 32'h77);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 1'b1, 10'd64, 32'h0);
    check("R1 PLL word after reset", 32'h0001A008, 1'b0, 1'b0);
    access(1'b0, 1'b1, 10'd3, 32'h0);
    check("R1 protect after reset", 32'h1, 1'b0, 1'b0);
    access(1'b1, 1'b0, 10'd0, 32'h1);
    check("R4 locked after reset", 32'h0, 1'b1, 1'b0);
    access(1'b0, 1'b1, 10'd0, 32'h0);
    check("R7 word 0 after reset", 32'h0, 1'b0, 1'b0);

    finish_run();
  end
endmodule